// File: doc/BRIEF.md
# SIMD Signed Dot-Product Accumulator

This block is a vector datapath stage. It splits a 128-bit vector into lanes and forms a grouped, widening, signed multiply-reduce in each lane. In each lane, a group of narrow signed integers from the first source is multiplied element by element with the matching group from the second source. The products are summed, and the sum is added to the corresponding wider lane of an accumulator operand. The result has the accumulator's width and is meant to replace the accumulator value. All lanes are computed at once.

A two-bit mode picks the element and lane widths:
- bytes grouped by four into 32-bit lanes;
- halfwords grouped by two into 32-bit lanes;
- halfwords grouped by four into 64-bit lanes.

An indexed option replaces the per-lane groups of the second source with a single group, chosen by an index and broadcast to every lane. The first source and the accumulator stay per lane.

The result is registered. A valid strobe on the input produces a valid strobe with the result one clock later. The block produces no status flags and has no per-lane enables.

Top module: `simd_dot_acc`

## Requirements
- R1: With mode = 0, each 32-bit lane of the result equals that lane of acc_in plus the sum of four products of signed bytes, one taken from src_a and one from src_b in the same lane.
- R2: With mode = 1, each 32-bit lane equals that lane of acc_in plus the sum of two products of signed halfwords taken from the same lane of src_a and src_b.
- R3: With mode = 2, each 64-bit lane equals that lane of acc_in plus the sum of four products of signed halfwords taken from the same 64-bit lane of src_a and src_b.
- R4: Lane e, element j reads narrow element number (elements-per-lane × e + j) of each source. Lane 0 and element 0 sit at the least significant bits, and no element leaks into another lane.
- R5: Every product is taken with full sign extension of both factors. For example, four products of (−128)×(−128) in mode 0 add 65536 to the lane.
- R6: Accumulation wraps modulo 2 to the power of the lane width. No saturation is applied and no overflow is reported.
- R7: With idx_en = 1, every lane uses one group of src_b instead of its own. In modes 0 and 1 this is 32-bit group idx, where group 0 is bits 31:0. In mode 2 it is 64-bit group idx[0], and idx[1] is ignored. src_a and acc_in stay per lane.
- R8: With idx_en = 0, the value of idx has no effect on the result.
- R9: out_valid is high in the cycle after each cycle with in_valid high, and low after each cycle with in_valid low. out_data carries the result in that same cycle.
- R10: While in_valid is low, out_data holds its previous value, whatever the other inputs do.
- R11: While rst_n is low, out_valid is 0 and out_data is 0.
- R12: Mode 3 is reserved. It returns acc_in unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| mode | input | 2 | 0: 8b×4→32, 1: 16b×2→32, 2: 16b×4→64, 3: pass accumulator |
| idx_en | input | 1 | Broadcast one group of src_b to all lanes |
| idx | input | 2 | Group number used when idx_en is high |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| acc_in | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result present |
| out_data | output | 128 | Accumulated result |

## Verification
Each result is due exactly one rising edge after the cycle in which its operands are presented with in_valid high. The driver applies operands on falling edges and queues the expected value when it presents them. The monitor compares on the falling edge that follows the capturing rising edge, so every queued item is matched in order against exactly one out_valid pulse. The hold checks for idle cycles read out_data one falling edge after in_valid drops. At the end the queue must be empty, which catches any lost result.

// File: rtl/simd_dot_pkg.sv
package simd_dot_pkg;

  typedef enum logic [1:0] {
    DM_B4_W32  = 2'd0,
    DM_H2_W32  = 2'd1,
    DM_H4_W64  = 2'd2,
    DM_PASS    = 2'd3
  } dot_mode_e;

  // sign-extended product of two signed bytes
  function automatic logic [31:0] mul_b(input logic [7:0] x, input logic [7:0] y);
    logic signed [15:0] xs, ys, p;
    xs = {{8{x[7]}}, x};
    ys = {{8{y[7]}}, y};
    p  = xs * ys;
    return {{16{p[15]}}, p};
  endfunction

  // sign-extended product of two signed halfwords
  function automatic logic [31:0] mul_h(input logic [15:0] x, input logic [15:0] y);
    logic signed [31:0] xs, ys, p;
    xs = {{16{x[15]}}, x};
    ys = {{16{y[15]}}, y};
    p  = xs * ys;
    return p;
  endfunction

  function automatic logic [31:0] dot_b4(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] s;
    s = '0;
    for (int j = 0; j < 4; j++) s = s + mul_b(a[8*j +: 8], b[8*j +: 8]);
    return s;
  endfunction

  function automatic logic [31:0] dot_h2(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] s;
    s = '0;
    for (int j = 0; j < 2; j++) s = s + mul_h(a[16*j +: 16], b[16*j +: 16]);
    return s;
  endfunction

  function automatic logic [63:0] dot_h4(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] s;
    logic [31:0] p;
    s = '0;
    for (int j = 0; j < 4; j++) begin
      p = mul_h(a[16*j +: 16], b[16*j +: 16]);
      s = s + {{32{p[31]}}, p};
    end
    return s;
  endfunction

endpackage

// File: rtl/simd_dot_bsel.sv
module simd_dot_bsel #(
  parameter int VEC_W = 128,
  localparam int N32 = VEC_W / 32,
  localparam int N64 = VEC_W / 64,
  localparam int IDX_W = $clog2(VEC_W / 32)
) (
  input  logic               idx_en,
  input  logic               wide,
  input  logic [IDX_W-1:0]   idx,
  input  logic [VEC_W-1:0]   b_in,
  output logic [VEC_W-1:0]   b_eff
);

  logic [31:0] grp32;
  logic [63:0] grp64;
  int          sel64;

  always_comb begin
    sel64 = int'(idx) % N64;
    grp32 = b_in[32*int'(idx) +: 32];
    grp64 = b_in[64*sel64 +: 64];
  end

  logic [VEC_W-1:0] bc32, bc64;

  for (genvar l = 0; l < N32; l++) begin : g_bc32
    assign bc32[32*l +: 32] = grp32;
  end
  for (genvar l = 0; l < N64; l++) begin : g_bc64
    assign bc64[64*l +: 64] = grp64;
  end

  always_comb begin
    if (!idx_en)   b_eff = b_in;
    else if (wide) b_eff = bc64;
    else           b_eff = bc32;
  end

endmodule

// File: rtl/simd_dot_lane32.sv
module simd_dot_lane32 (
  input  logic        half,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [31:0] acc,
  output logic [31:0] res
);
  import simd_dot_pkg::*;

  logic [31:0] sum_b4, sum_h2, sum_sel;

  assign sum_b4  = dot_b4(a, b);
  assign sum_h2  = dot_h2(a, b);
  assign sum_sel = half ? sum_h2 : sum_b4;
  assign res     = acc + sum_sel;

endmodule

// File: rtl/simd_dot_lane64.sv
module simd_dot_lane64 (
  input  logic [63:0] a,
  input  logic [63:0] b,
  input  logic [63:0] acc,
  output logic [63:0] res
);
  import simd_dot_pkg::*;

  logic [63:0] sum_h4;

  assign sum_h4 = dot_h4(a, b);
  assign res    = acc + sum_h4;

endmodule

// File: rtl/simd_dot_acc.sv
module simd_dot_acc #(
  parameter int VEC_W = 128,
  localparam int N32 = VEC_W / 32,
  localparam int N64 = VEC_W / 64,
  localparam int IDX_W = $clog2(VEC_W / 32)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         mode,
  input  logic               idx_en,
  input  logic [IDX_W-1:0]   idx,
  input  logic [VEC_W-1:0]   src_a,
  input  logic [VEC_W-1:0]   src_b,
  input  logic [VEC_W-1:0]   acc_in,
  output logic               out_valid,
  output logic [VEC_W-1:0]   out_data
);
  import simd_dot_pkg::*;

  dot_mode_e mode_e;
  assign mode_e = dot_mode_e'(mode);

  logic is_wide, is_half;
  assign is_wide = (mode_e == DM_H4_W64);
  assign is_half = (mode_e == DM_H2_W32);

  // second operand after optional broadcast
  logic [VEC_W-1:0] b_eff;

  simd_dot_bsel #(.VEC_W(VEC_W)) u_bsel (
    .idx_en (idx_en),
    .wide   (is_wide),
    .idx    (idx),
    .b_in   (src_b),
    .b_eff  (b_eff)
  );

  logic [VEC_W-1:0] res_narrow, res_wide, res_next;

  for (genvar l = 0; l < N32; l++) begin : g_l32
    simd_dot_lane32 u_lane (
      .half (is_half),
      .a    (src_a[32*l +: 32]),
      .b    (b_eff[32*l +: 32]),
      .acc  (acc_in[32*l +: 32]),
      .res  (res_narrow[32*l +: 32])
    );
  end

  for (genvar l = 0; l < N64; l++) begin : g_l64
    simd_dot_lane64 u_lane (
      .a    (src_a[64*l +: 64]),
      .b    (b_eff[64*l +: 64]),
      .acc  (acc_in[64*l +: 64]),
      .res  (res_wide[64*l +: 64])
    );
  end

  always_comb begin
    unique case (mode_e)
      DM_B4_W32, DM_H2_W32: res_next = res_narrow;
      DM_H4_W64:            res_next = res_wide;
      default:              res_next = acc_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= res_next;
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  a_r12_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd3) |=> (out_data == $past(acc_in)));
  a_r1_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_a == '0) |=> (out_data == $past(acc_in)));

endmodule

// File: tb/tb_simd_dot_acc.sv
module tb_simd_dot_acc;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   mode = '0;
  logic         idx_en = 1'b0;
  logic [1:0]   idx = '0;
  logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int n_chk = 0;
  int n_err = 0;

  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic [127:0] last_exp = '0;

  always #(CLK_P/2) clk = ~clk;

  simd_dot_acc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .idx_en(idx_en), .idx(idx), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .out_valid(out_valid), .out_data(out_data)
  );

  // independent per-lane integer model
  function automatic logic [127:0] ref_calc(input logic [127:0] a, input logic [127:0] b,
      input logic [127:0] acc, input logic [1:0] md, input logic ie, input logic [1:0] ix);
    logic [127:0] bv, res, t, lv;
    logic [63:0]  g;
    int gw, ew, ng, gi;
    longint s, x, y;
    if (md == 2'd3) return acc;
    gw = (md == 2'd2) ? 64 : 32;
    ew = (md == 2'd0) ? 8 : 16;
    ng = gw / ew;
    bv = b;
    if (ie) begin
      gi = (md == 2'd2) ? int'(ix[0]) : int'(ix);
      t  = b >> (gw * gi);
      g  = t[63:0];
      bv = (gw == 64) ? {g, g} : {4{g[31:0]}};
    end
    res = '0;
    for (int l = 0; l < 128 / gw; l++) begin
      t = acc >> (l * gw);
      s = (gw == 64) ? longint'(t[63:0]) : longint'($signed(t[31:0]));
      for (int k = 0; k < ng; k++) begin
        t = a >> (l * gw + k * ew);
        x = (ew == 8) ? longint'($signed(t[7:0])) : longint'($signed(t[15:0]));
        t = bv >> (l * gw + k * ew);
        y = (ew == 8) ? longint'($signed(t[7:0])) : longint'($signed(t[15:0]));
        s = s + x * y;
      end
      lv = (gw == 64) ? {64'd0, s[63:0]} : {96'd0, s[31:0]};
      res = res | (lv << (l * gw));
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc,
                      input logic [1:0] md, input logic ie, input logic [1:0] ix, input string tag);
    @(negedge clk);
    src_a = a; src_b = b; acc_in = acc; mode = md; idx_en = ie; idx = ix;
    in_valid = 1'b1;
    last_exp = ref_calc(a, b, acc, md, ie, ix);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
  endtask

  // idle cycle with scrambled operands; checks R9 and R10 at the ports
  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0;
    src_a = {4{$urandom}}; src_b = {4{$urandom}}; acc_in = {4{$urandom}};
    mode = 2'($urandom); idx_en = 1'($urandom);
    @(negedge clk);
    check("R9 idle valid", {127'd0, out_valid}, 128'd0);
    check("R10 hold", out_data, last_exp);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R9: unexpected out_valid act=1 exp=0");
      end else begin
        check(tag_q.pop_front(), out_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] a, b, c, r0, r1;
    repeat (3) @(negedge clk);
    check("R11 reset valid", {127'd0, out_valid}, 128'd0);
    check("R11 reset data", out_data, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: byte mode, ramp values
    for (int i = 0; i < 16; i++) a[8*i +: 8] = 8'(i + 1);
    send(a, {16{8'h01}}, 128'd0, 2'd0, 1'b0, 2'd0, "R1 ramp");
    send(a, {16{8'hFF}}, {4{32'd100}}, 2'd0, 1'b0, 2'd0, "R1 neg");
    // R4: single element in lane 0 element 0, then top element of lane 3
    send(128'h3, 128'h5, 128'd0, 2'd0, 1'b0, 2'd0, "R4 low elem");
    send({8'h07, 120'd0}, {8'h09, 120'd0}, 128'd0, 2'd0, 1'b0, 2'd0, "R4 top elem");
    send({64'd0, 16'h0002, 48'd0}, {64'd0, 16'h0003, 48'd0}, 128'd0, 2'd2, 1'b0, 2'd0, "R4 wide elem");
    // R5: extreme negatives
    send({16{8'h80}}, {16{8'h80}}, 128'd0, 2'd0, 1'b0, 2'd0, "R5 byte min");
    send({16{8'h7F}}, {16{8'h80}}, 128'd0, 2'd0, 1'b0, 2'd0, "R5 byte mix");
    send({8{16'h8000}}, {8{16'h8000}}, 128'd0, 2'd2, 1'b0, 2'd0, "R5 half min wide");
    idle_check();
    check("R5 const", last_exp, {2{64'h0000_0001_0000_0000}});
    // R6: wraps
    send({8{16'h8000}}, {8{16'h8000}}, {4{32'h8000_0000}}, 2'd1, 1'b0, 2'd0, "R6 wrap32");
    send(128'h1, 128'h1, {2{64'h7FFF_FFFF_FFFF_FFFF}}, 2'd2, 1'b0, 2'd0, "R6 wrap64");
    idle_check();
    check("R6 const", last_exp, {64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000});
    // R12: reserved mode
    send(rnd128(), rnd128(), 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 2'd3, 1'b0, 2'd0, "R12 pass");
    idle_check();
    // random per mode: R1 R2 R3
    for (int i = 0; i < 200; i++) send(rnd128(), rnd128(), rnd128(), 2'd0, 1'b0, 2'd0, "R1 rand");
    idle_check();
    for (int i = 0; i < 200; i++) send(rnd128(), rnd128(), rnd128(), 2'd1, 1'b0, 2'd0, "R2 rand");
    idle_check();
    for (int i = 0; i < 200; i++) send(rnd128(), rnd128(), rnd128(), 2'd2, 1'b0, 2'd0, "R3 rand");
    idle_check();
    // R7: indexed, every mode and index
    for (int m = 0; m < 3; m++)
      for (int k = 0; k < 4; k++)
        for (int i = 0; i < 20; i++)
          send(rnd128(), rnd128(), rnd128(), 2'(m), 1'b1, 2'(k), "R7 indexed");
    idle_check();
    // R8: idx ignored when idx_en low
    a = rnd128(); b = rnd128(); c = rnd128();
    for (int m = 0; m < 3; m++) begin
      send(a, b, c, 2'(m), 1'b0, 2'd0, "R8 idx0");
      r0 = last_exp;
      send(a, b, c, 2'(m), 1'b0, 2'd3, "R8 idx3");
      r1 = last_exp;
      check("R8 model", r1, r0);
    end
    idle_check();
    // mixed stream across modes
    for (int i = 0; i < 300; i++)
      send(rnd128(), rnd128(), rnd128(), 2'($urandom), 1'($urandom), 2'($urandom), "R9 mixed");
    idle_check();
    repeat (3) @(negedge clk);
    check("R9 drained", 128'(exp_q.size()), 128'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule